// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide host interface of an eight-line interrupt controller. It has two addresses. Address 0 takes command bytes: a byte with bit 4 set starts a new initialization. A byte with bit 4 clear and bit 3 set is a read/poll command. Any other byte is an operation command, and bits 7:5 select the action. Address 1 carries the follow-on initialization words while a sequence is open. Outside a sequence, an address-1 write loads the mask register.

The block holds the configuration that the priority resolver uses: mask, vector base, auto end-of-interrupt, special fully nested mode, special mask and rotate-on-auto-EOI. The request and in-service registers belong to the resolver and arrive here as inputs. Each operation command becomes a single-cycle strobe toward the resolver, with the line number taken from bits 2:0. The resolver also supplies the highest pending line. A poll read returns it and sends back a strobe that clears that line.

Top module: `pic_prog_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every configuration output is cleared, the read select is set to requests, poll is disarmed and the port is in normal mode.
- R2: In the cycle of an address-0 write with bit 4 set, `init_pulse` is high. After that edge the mask, vector base, auto-EOI, nested mode, special mask, rotate-on-auto-EOI, read select and poll are all cleared. Data bit 0 is recorded as "fourth word expected".
- R3: The first address-1 write after an initialization start sets `vec_base` to the data with bits 2:0 forced to 0.
- R4: The second address-1 write is discarded. If a fourth word is expected, the port then waits for it. Otherwise it returns to normal mode.
- R5: The fourth word sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, and the port returns to normal mode.
- R6: In normal mode an address-1 write loads `imr`. A non-poll read at address 1 returns `imr` in the same cycle.
- R7: In a read/poll command (address 0, bit 4 = 0, bit 3 = 1):
  - Bit 2 = 1 arms poll.
  - If bit 1 = 1, bit 0 sets the read select (1 = in-service, 0 = request).
  - If bit 6 = 1, bit 5 sets `special_mask`.
- R8: An operation command (address 0, bit 4 = 0, bit 3 = 0) drives strobes in its write cycle, with `cmd_line` equal to data bits 2:0. The code in bits 7:5 selects the strobes:
  - 1: `eoi_pulse` only.
  - 3: `eoi_pulse` and `eoi_specific`.
  - 5: `eoi_pulse` and `eoi_rotate`.
  - 7: `eoi_pulse`, `eoi_specific` and `eoi_rotate`.
  - 6: `prio_set_pulse` only.
- R9: Operation codes 0 and 4 set `rotate_aeoi` from bit 7 and raise no strobe.
- R10: When poll is armed, the next read at either address is a poll read:
  - If `poll_valid` is high, it returns `poll_line` zero-extended and raises `poll_clr` in that cycle.
  - Otherwise it returns 7 and `poll_clr` stays low.
  - Either way poll is then disarmed, and the following read is a normal read.
- R11: A non-poll read at address 0 returns `isr_in` when the read select is 1 and `irr_in` when it is 0.
- R12: Operation code 2 raises no strobe and leaves the mask, special mask and rotate-on-auto-EOI unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable, one cycle per byte |
| rd_en | input | 1 | Read enable, one cycle per byte |
| addr | input | 1 | Register address (0 command, 1 data) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irr_in | input | 8 | Request register from the resolver |
| isr_in | input | 8 | In-service register from the resolver |
| poll_valid | input | 1 | Resolver has a pending line to report |
| poll_line | input | 3 | Highest-priority pending line |
| imr | output | 8 | Mask register |
| vec_base | output | 8 | Vector base, low three bits zero |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| nested_mode | output | 1 | Special fully nested mode |
| special_mask | output | 1 | Special mask mode |
| rotate_aeoi | output | 1 | Rotate priority on automatic end-of-interrupt |
| init_pulse | output | 1 | Initialization start; resolver clears its state and output |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| eoi_specific | output | 1 | Qualifies eoi_pulse: clear cmd_line rather than the highest in service |
| eoi_rotate | output | 1 | Qualifies eoi_pulse: make the cleared line lowest priority |
| prio_set_pulse | output | 1 | Make cmd_line the lowest priority |
| cmd_line | output | 3 | Line number from write data bits 2:0 |
| poll_clr | output | 1 | Clear request and in-service of poll_line |

## Verification
The strobes, `rdata` and `poll_clr` are combinational, so they are due in the same cycle as `wr_en` or `rd_en`. The bench samples them 1 ns after it drives the inputs on a falling edge. Every register result is due one edge later. These include the mask, vector base, mode flags, read select, poll arming and the initialization step. The bench checks them only after the next rising edge, either directly or with a read in the following cycle. The sweeps cover all 256 mask values, all 256 first words with every fourth-word option, every operation-command byte and every read/poll command byte.

// File: rtl/pic_port_pkg.sv
`timescale 1ns/1ps
// Package: shared types and command bit positions for the programming port.
// Assumes byte-wide commands with fixed bit positions.
package pic_port_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_BASE    = 2'd1,
        ST_CASCADE = 2'd2,
        ST_MODE    = 2'd3
    } init_step_e;

    typedef enum logic [2:0] {
        OP_ROT_OFF = 3'd0,
        OP_EOI     = 3'd1,
        OP_NOP     = 3'd2,
        OP_SEOI    = 3'd3,
        OP_ROT_ON  = 3'd4,
        OP_REOI    = 3'd5,
        OP_SETPRI  = 3'd6,
        OP_RSEOI   = 3'd7
    } op_code_e;

    localparam int INIT_BIT   = 4;
    localparam int READ_BIT   = 3;
    localparam int POLL_BIT   = 2;
    localparam int SELV_BIT   = 1;
    localparam int SEL_BIT    = 0;
    localparam int SMASKV_BIT = 6;
    localparam int SMASK_BIT  = 5;
    localparam int FOURTH_BIT = 0;
    localparam int NEST_BIT   = 4;
    localparam int AEOI_BIT   = 1;
endpackage

// File: rtl/pic_cmd_decode.sv
`timescale 1ns/1ps
// Module: pic_cmd_decode
// Purely combinational decode of an address-0 write into an initialization
// start, a read/poll command or an operation command with its strobes.
// Assumes wr_en is high for exactly one cycle per byte.
module pic_cmd_decode
    import pic_port_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W)
) (
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              init_start,
    output logic              read_cmd_wr,
    output logic              eoi_pulse,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic              prio_set_pulse,
    output logic              rot_aeoi_wr,
    output logic              rot_aeoi_val,
    output logic [LINE_W-1:0] cmd_line
);
    logic     ctl_wr;
    logic     op_wr;
    op_code_e code;

    // Classify the command byte by its discriminating bits.
    always_comb begin
        ctl_wr      = wr_en && !addr;
        init_start  = ctl_wr && wdata[INIT_BIT];
        read_cmd_wr = ctl_wr && !wdata[INIT_BIT] && wdata[READ_BIT];
        op_wr       = ctl_wr && !wdata[INIT_BIT] && !wdata[READ_BIT];
        code        = op_code_e'(wdata[DATA_W-1 -: 3]);
        cmd_line    = wdata[LINE_W-1:0];
    end

    // Turn the operation code into resolver strobes.
    always_comb begin
        eoi_pulse      = 1'b0;
        eoi_specific   = 1'b0;
        eoi_rotate     = 1'b0;
        prio_set_pulse = 1'b0;
        rot_aeoi_wr    = 1'b0;
        rot_aeoi_val   = wdata[DATA_W-1];
        if (op_wr) begin
            case (code)
                OP_ROT_OFF, OP_ROT_ON: rot_aeoi_wr = 1'b1;
                OP_EOI:    eoi_pulse = 1'b1;
                OP_SEOI:   begin eoi_pulse = 1'b1; eoi_specific = 1'b1; end
                OP_REOI:   begin eoi_pulse = 1'b1; eoi_rotate = 1'b1; end
                OP_RSEOI:  begin eoi_pulse = 1'b1; eoi_specific = 1'b1; eoi_rotate = 1'b1; end
                OP_SETPRI: prio_set_pulse = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
`timescale 1ns/1ps
// Module: pic_init_seq
// Steps through the initialization words on the data address and holds
// the mask, vector base and mode flags. Normal data writes load the mask.
// Assumes start and data_wr are never high together (they differ in addr).
module pic_init_seq
    import pic_port_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W),
    localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'((1 << LINE_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic              nested_mode
);
    init_step_e step;
    logic       fourth_due;

    // Initialization step machine and the registers it loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step        <= ST_NORMAL;
            fourth_due  <= 1'b0;
            imr         <= '0;
            vec_base    <= '0;
            auto_eoi    <= 1'b0;
            nested_mode <= 1'b0;
        end else if (start) begin
            step        <= ST_BASE;
            fourth_due  <= wdata[FOURTH_BIT];
            imr         <= '0;
            vec_base    <= '0;
            auto_eoi    <= 1'b0;
            nested_mode <= 1'b0;
        end else if (data_wr) begin
            case (step)
                ST_NORMAL:  imr <= wdata;
                ST_BASE: begin
                    vec_base <= wdata & BASE_MASK;
                    step     <= ST_CASCADE;
                end
                ST_CASCADE: step <= fourth_due ? ST_MODE : ST_NORMAL;
                ST_MODE: begin
                    nested_mode <= wdata[NEST_BIT];
                    auto_eoi    <= wdata[AEOI_BIT];
                    step        <= ST_NORMAL;
                end
                default:    step <= ST_NORMAL;
            endcase
        end
    end

    // R2: an initialization start leaves mask and modes cleared
    p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (imr == '0 && vec_base == '0 && !auto_eoi && !nested_mode));
    // R6: the mask only moves on a write
    p_imr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && !start) |=> $stable(imr));
    // R5: the fourth word always closes the sequence
    p_mode_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !start && step == ST_MODE) |=> step == ST_NORMAL);
    // R3: the vector base never carries low line bits
    p_base_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && step == ST_BASE) |=> vec_base[LINE_W-1:0] == '0);
endmodule

// File: rtl/pic_read_ctl.sv
`timescale 1ns/1ps
// Module: pic_read_ctl
// Holds the read select, poll arming and special mask. Drives the read
// data for register reads and one-shot poll reads.
// Assumes a read command write and a read are not issued in the same cycle.
module pic_read_ctl #(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W),
    localparam logic [DATA_W-1:0] SPURIOUS = DATA_W'(DATA_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_start,
    input  logic              cmd_wr,
    input  logic              poll_arm,
    input  logic              sel_valid,
    input  logic              sel_val,
    input  logic              smask_valid,
    input  logic              smask_val,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] irr_in,
    input  logic [DATA_W-1:0] isr_in,
    input  logic [DATA_W-1:0] imr,
    input  logic              poll_valid,
    input  logic [LINE_W-1:0] poll_line,
    output logic [DATA_W-1:0] rdata,
    output logic              poll_clr,
    output logic              special_mask
);
    logic rd_isr;
    logic poll_armed;

    // Read/poll command flags; poll is consumed by the next read.
    always_ff @(posedge clk) begin
        if (!rst_n || init_start) begin
            rd_isr       <= 1'b0;
            poll_armed   <= 1'b0;
            special_mask <= 1'b0;
        end else if (cmd_wr) begin
            if (poll_arm)    poll_armed   <= 1'b1;
            if (sel_valid)   rd_isr       <= sel_val;
            if (smask_valid) special_mask <= smask_val;
        end else if (rd_en && poll_armed) begin
            poll_armed <= 1'b0;
        end
    end

    // Read data multiplexer and poll clear strobe.
    always_comb begin
        rdata    = '0;
        poll_clr = 1'b0;
        if (rd_en) begin
            if (poll_armed) begin
                rdata    = poll_valid ? DATA_W'(poll_line) : SPURIOUS;
                poll_clr = poll_valid;
            end else if (addr) begin
                rdata = imr;
            end else begin
                rdata = rd_isr ? isr_in : irr_in;
            end
        end
    end

    // R10: a poll read consumes the armed poll
    p_poll_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !cmd_wr) |=> !poll_armed);
    // R10: the clear strobe needs a read and a pending line
    p_clr_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        poll_clr |-> (rd_en && poll_valid));
endmodule

// File: rtl/pic_prog_port.sv
`timescale 1ns/1ps
// Module: pic_prog_port (top)
// Two-address byte programming port of one interrupt controller. It decodes
// command bytes, sequences initialization words, holds the configuration and
// serves register and poll reads. Strobes toward the priority resolver are
// combinational and valid in the write cycle.
// Assumes at most one of wr_en/rd_en is high per cycle.
module pic_prog_port #(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] irr_in,
    input  logic [DATA_W-1:0] isr_in,
    input  logic              poll_valid,
    input  logic [LINE_W-1:0] poll_line,
    output logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic              nested_mode,
    output logic              special_mask,
    output logic              rotate_aeoi,
    output logic              init_pulse,
    output logic              eoi_pulse,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic              prio_set_pulse,
    output logic [LINE_W-1:0] cmd_line,
    output logic              poll_clr
);
    import pic_port_pkg::*;

    logic read_cmd_wr;
    logic rot_aeoi_wr;
    logic rot_aeoi_val;

    pic_cmd_decode #(.DATA_W(DATA_W)) i_decode (
        .wr_en          (wr_en),
        .addr           (addr),
        .wdata          (wdata),
        .init_start     (init_pulse),
        .read_cmd_wr    (read_cmd_wr),
        .eoi_pulse      (eoi_pulse),
        .eoi_specific   (eoi_specific),
        .eoi_rotate     (eoi_rotate),
        .prio_set_pulse (prio_set_pulse),
        .rot_aeoi_wr    (rot_aeoi_wr),
        .rot_aeoi_val   (rot_aeoi_val),
        .cmd_line       (cmd_line)
    );

    pic_init_seq #(.DATA_W(DATA_W)) i_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (init_pulse),
        .data_wr     (wr_en && addr),
        .wdata       (wdata),
        .imr         (imr),
        .vec_base    (vec_base),
        .auto_eoi    (auto_eoi),
        .nested_mode (nested_mode)
    );

    pic_read_ctl #(.DATA_W(DATA_W)) i_read (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_start   (init_pulse),
        .cmd_wr       (read_cmd_wr),
        .poll_arm     (wdata[POLL_BIT]),
        .sel_valid    (wdata[SELV_BIT]),
        .sel_val      (wdata[SEL_BIT]),
        .smask_valid  (wdata[SMASKV_BIT]),
        .smask_val    (wdata[SMASK_BIT]),
        .rd_en        (rd_en),
        .addr         (addr),
        .irr_in       (irr_in),
        .isr_in       (isr_in),
        .imr          (imr),
        .poll_valid   (poll_valid),
        .poll_line    (poll_line),
        .rdata        (rdata),
        .poll_clr     (poll_clr),
        .special_mask (special_mask)
    );

    // Rotate-on-auto-EOI flag, written by operation codes 0 and 4.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) rotate_aeoi <= 1'b0;
        else if (rot_aeoi_wr)     rotate_aeoi <= rot_aeoi_val;
    end

    // R8: resolver strobes only come from an operation write at address 0
    p_strobe_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse || prio_set_pulse) |-> (wr_en && !addr && !wdata[INIT_BIT] && !wdata[READ_BIT]));
    // R8: specific and rotate qualifiers never appear without an EOI
    p_qual_needs_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_specific || eoi_rotate) |-> eoi_pulse);
    // R9: rotate flag only changes after a write
    p_rot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rotate_aeoi));
endmodule

// File: tb/test_pic_prog_port.sv
`timescale 1ns/1ps
module test_pic_prog_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, rdata, irr_in = 8'hA5, isr_in = 8'h3C;
    logic       poll_valid = 1'b0;
    logic [2:0] poll_line = '0;
    logic [7:0] imr, vec_base;
    logic       auto_eoi, nested_mode, special_mask, rotate_aeoi;
    logic       init_pulse, eoi_pulse, eoi_specific, eoi_rotate, prio_set_pulse, poll_clr;
    logic [2:0] cmd_line;

    int tests = 0;
    int fails = 0;
    logic [7:0] s_rd;
    logic [7:0] s_str;   // {init,eoi,spec,rot,setpri,line}
    logic       s_clr;

    always #5 clk = ~clk;

    pic_prog_port i_pic_prog_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .poll_valid(poll_valid), .poll_line(poll_line), .imr(imr),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .nested_mode(nested_mode),
        .special_mask(special_mask), .rotate_aeoi(rotate_aeoi),
        .init_pulse(init_pulse), .eoi_pulse(eoi_pulse),
        .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
        .prio_set_pulse(prio_set_pulse), .cmd_line(cmd_line), .poll_clr(poll_clr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        #1 s_str = {init_pulse, eoi_pulse, eoi_specific, eoi_rotate, prio_set_pulse, cmd_line};
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 s_rd = rdata; s_clr = poll_clr;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] m_imr;
        logic       m_rot, m_sel, m_smask;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check("R1 imr", imr, 8'h00);
        check("R1 vec_base", vec_base, 8'h00);
        check("R1 flags", {4'b0, auto_eoi, nested_mode, special_mask, rotate_aeoi}, 8'h00);
        rd(1'b1); check("R1 read addr1", s_rd, 8'h00);
        rd(1'b0); check("R1 read addr0 gives requests", s_rd, irr_in);

        // R6: every mask value
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 8'(v));
            rd(1'b1); check("R6 mask readback", s_rd, 8'(v));
        end

        // R2..R5: initialization with every first word and both fourth-word options
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dv;
            dv = 8'(d);
            wr(1'b1, 8'hFF);
            wr(1'b0, 8'h80);              // rotate-on-auto-EOI on
            wr(1'b0, 8'h6B);              // special mask on, select in-service
            wr(1'b0, 8'h10 | {7'b0, dv[0]});
            check("R2 init_pulse", {7'b0, s_str[7]}, 8'h01);
            check("R2 cleared", {imr, 4'b0, auto_eoi, nested_mode, special_mask, rotate_aeoi} == 16'h0 ? 8'h0 : 8'h1, 8'h0);
            wr(1'b1, dv);
            check("R3 vector base", vec_base, dv & 8'hF8);
            wr(1'b1, 8'hC3);
            check("R4 cascade word ignored", imr, 8'h00);
            if (dv[0]) begin
                wr(1'b1, dv);
                check("R5 modes", {6'b0, nested_mode, auto_eoi}, {6'b0, dv[4], dv[1]});
            end else begin
                check("R4 no fourth word", {6'b0, nested_mode, auto_eoi}, 8'h00);
            end
            wr(1'b1, 8'h5A);
            check("R4 back to normal", imr, 8'h5A);
            rd(1'b0); check("R11 select reset to requests", s_rd, irr_in);
        end
        m_imr = 8'h5A; m_rot = 1'b0; m_sel = 1'b0; m_smask = 1'b0;

        // R8, R9, R12: every operation command byte
        for (int k = 0; k < 64; k++) begin
            logic [7:0] v;
            logic [2:0] c;
            logic [7:0] exp;
            v = {2'(k >> 4), 1'(k >> 3), 2'b00, 3'(k)};
            v = {3'(k >> 3), 2'b00, 3'(k)};
            c = v[7:5];
            exp = {1'b0, c[0], c[1] & c[0], c[2] & c[0], c == 3'd6, v[2:0]};
            wr(1'b0, v);
            check(c == 3'd2 ? "R12 no strobe" : "R8 strobes", s_str, exp);
            if (c == 3'd0 || c == 3'd4) m_rot = v[7];
            check("R9 rotate flag", {7'b0, rotate_aeoi}, {7'b0, m_rot});
            if (c == 3'd2) begin
                rd(1'b1); check("R12 mask kept", s_rd, m_imr);
                check("R12 special mask kept", {7'b0, special_mask}, {7'b0, m_smask});
            end
        end

        // R7, R10, R11: every read/poll command byte
        for (int k = 0; k < 64; k++) begin
            logic [7:0] v;
            logic       pv;
            logic [7:0] nrm;
            v = {3'(k >> 3), 2'b01, 3'(k)};
            pv = 1'(k >> 3) ^ 1'(k);
            poll_valid = pv;
            poll_line = 3'(k * 3 + 1);
            irr_in = 8'(k * 7 + 3);
            isr_in = 8'(k * 11 + 5);
            wr(1'b0, v);
            if (v[1]) m_sel = v[0];
            if (v[6]) m_smask = v[5];
            check("R7 special mask", {7'b0, special_mask}, {7'b0, m_smask});
            nrm = m_sel ? isr_in : irr_in;
            rd(1'b0);
            if (v[2]) begin
                check("R10 poll data", s_rd, pv ? {5'b0, poll_line} : 8'h07);
                check("R10 poll clear", {7'b0, s_clr}, {7'b0, pv});
                rd(1'b0);
                check("R10 poll disarmed", s_rd, nrm);
            end else begin
                check("R11 register read", s_rd, nrm);
                check("R7 no clear without poll", {7'b0, s_clr}, 8'h00);
            end
            rd(1'b1); check("R6 addr1 read", s_rd, m_imr);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule